// File: doc/BRIEF.md
# Two-Stage Instruction Address Queue

This block holds the addresses of two instructions at once: the front entry names the instruction now executing, and the back entry names the one that will run after it. Keeping both is what makes delayed branching work. When a branch resolves, its target goes into the back entry, while the instruction already queued in the back still moves to the front and executes. Each entry is 32 bits. The upper 30 bits are a word offset and the lower 2 bits are the privilege level of that instruction. Each entry also carries a space identifier, whose width is set by a parameter and which can be left out entirely.

An advance strobe shifts the queue. The front entry takes the back entry, and the back entry becomes either the sequential successor (one word further on, same privilege) or the branch target. A restore strobe loads both entries at once from externally saved values; interruption return uses this path. The block compares the privilege levels of the two entries and raises higher-privilege and lower-privilege transfer trap flags when each is enabled. It also flags a taken-branch trap when the back entry came from a taken branch.

Top module: `insn_addr_queue`

## Requirements
- R1: While reset is asserted and immediately after it is released, the front offset output is 0x00000000 and the back offset output is 0x00000004 (word 1, privilege 0). Both space outputs are zero and all three trap flags are low.
- R2: On a clock edge with advance high and restore low, the front offset and front space take the values that the back offset and back space held before that edge.
- R3: On an advance without a taken branch, the back offset becomes the old back offset with bits [31:2] incremented by one, wrapping from all ones to zero. Bits [1:0] (privilege) and the back space are unchanged.
- R4: On an advance with branch-taken high, the back offset and back space take the branch target offset (privilege included in bits [1:0]) and the target space.
- R5: A restore strobe loads the front and back offsets and spaces from the saved-value inputs on the next edge. It takes priority over a simultaneous advance.
- R6: With neither advance nor restore, every entry holds its value, whatever the branch-taken and target inputs do.
- R7: The higher-privilege trap output is high exactly when its enable is high and the back entry's privilege level is numerically lower (more privileged) than the front's. Levels 0 to 3 are used, and 0 is the most privileged.
- R8: The lower-privilege trap output is high exactly when its enable is high and the back entry's privilege level is numerically higher than the front's.
- R9: With REDUCED_PRIV=1, levels 1, 2 and 3 count as one nonzero level. The privilege traps fire only on a change between level 0 and a nonzero level.
- R10: The taken-branch trap output is high exactly when its enable is high and the most recent advance or restore was an advance with a taken branch. A restore clears that record.
- R11: With SPACE_W=0 the space identifier is absent: both space outputs are a single bit tied to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| adv_i | input | 1 | Advance the queue by one instruction |
| br_taken_i | input | 1 | Branch taken at this advance |
| br_tgt_ofs_i | input | 32 | Branch target offset, privilege in bits [1:0] |
| br_tgt_spc_i | input | SPC_PW | Branch target space identifier |
| restore_i | input | 1 | Load both entries from saved values |
| rs_front_ofs_i | input | 32 | Saved front offset |
| rs_front_spc_i | input | SPC_PW | Saved front space |
| rs_back_ofs_i | input | 32 | Saved back offset |
| rs_back_spc_i | input | SPC_PW | Saved back space |
| hi_trap_en_i | input | 1 | Enable for the higher-privilege transfer trap |
| lo_trap_en_i | input | 1 | Enable for the lower-privilege transfer trap |
| br_trap_en_i | input | 1 | Enable for the taken-branch trap |
| front_ofs_o | output | 32 | Current instruction offset and privilege |
| front_spc_o | output | SPC_PW | Current instruction space |
| back_ofs_o | output | 32 | Following instruction offset and privilege |
| back_spc_o | output | SPC_PW | Following instruction space |
| hi_trap_o | output | 1 | Following instruction is more privileged |
| lo_trap_o | output | 1 | Following instruction is less privileged |
| br_trap_o | output | 1 | Following instruction is a taken-branch target |

## Verification
Every entry bit is driven directly to an output, so a corrupted front or back register is visible at the ports in the cycle after the edge that wrote it. A wrong back entry is seen a second time one advance later, when it moves into the front entry. A fault in the privilege comparison or in the taken-branch record shows on the trap flags within the same cycle. The bench runs a behavioural model in parallel with a full-privilege instance and with a reduced, space-less instance. It compares every output of both instances after each edge, so a divergence is reported in the cycle it first appears.

// File: rtl/iaq_pkg.sv
package iaq_pkg;
  localparam int OFS_W = 30;
  localparam int PL_W  = 2;
  localparam int ENT_W = OFS_W + PL_W;

  // source chosen for the back entry on an edge
  typedef enum logic [1:0] {
    BK_HOLD    = 2'd0,
    BK_SEQ     = 2'd1,
    BK_BRANCH  = 2'd2,
    BK_RESTORE = 2'd3
  } bk_src_e;

  // next word in linear order, privilege bits untouched
  function automatic logic [ENT_W-1:0] seq_succ(input logic [ENT_W-1:0] e);
    logic [OFS_W-1:0] w;
    w = e[ENT_W-1:PL_W] + OFS_W'(1);
    return {w, e[PL_W-1:0]};
  endfunction

  // privilege rank used for comparison; reduced mode folds 1..3 together
  function automatic logic [PL_W-1:0] priv_rank(input logic [PL_W-1:0] pl, input bit reduced);
    if (reduced) return {{(PL_W-1){1'b0}}, |pl};
    return pl;
  endfunction
endpackage

// File: rtl/iaq_ctl.sv
module iaq_ctl
  import iaq_pkg::*;
(
  input  logic    adv_i,
  input  logic    br_taken_i,
  input  logic    restore_i,
  output bk_src_e bk_src_o,
  output logic    front_ld_o,
  output logic    taken_ld_o,
  output logic    taken_d_o
);
  always_comb begin
    if (restore_i)               bk_src_o = BK_RESTORE;
    else if (adv_i && br_taken_i) bk_src_o = BK_BRANCH;
    else if (adv_i)              bk_src_o = BK_SEQ;
    else                         bk_src_o = BK_HOLD;
  end

  assign front_ld_o = restore_i | adv_i;
  assign taken_ld_o = restore_i | adv_i;
  assign taken_d_o  = (bk_src_o == BK_BRANCH);
endmodule

// File: rtl/iaq_entry.sv
module iaq_entry
  import iaq_pkg::*;
#(
  parameter int               SPACE_W = 32,
  parameter logic [ENT_W-1:0] RST_OFS = '0,
  localparam int              SPC_PW  = (SPACE_W == 0) ? 1 : SPACE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_i,
  input  logic [ENT_W-1:0]  ofs_d,
  input  logic [SPC_PW-1:0] spc_d,
  output logic [ENT_W-1:0]  ofs_q,
  output logic [SPC_PW-1:0] spc_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ofs_q <= RST_OFS;
    else if (ld_i) ofs_q <= ofs_d;
  end

  generate
    if (SPACE_W == 0) begin : g_no_space
      logic unused_spc;
      assign unused_spc = ^spc_d;
      assign spc_q = '0;
    end else begin : g_space
      logic [SPC_PW-1:0] spc_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    spc_r <= '0;
        else if (ld_i) spc_r <= spc_d;
      end
      assign spc_q = spc_r;
    end
  endgenerate
endmodule

// File: rtl/iaq_priv_cmp.sv
module iaq_priv_cmp
  import iaq_pkg::*;
#(
  parameter bit REDUCED_PRIV = 1'b0
) (
  input  logic [PL_W-1:0] front_pl_i,
  input  logic [PL_W-1:0] back_pl_i,
  output logic            back_higher_o,
  output logic            back_lower_o
);
  logic [PL_W-1:0] rf, rb;
  assign rf = priv_rank(front_pl_i, REDUCED_PRIV);
  assign rb = priv_rank(back_pl_i, REDUCED_PRIV);
  // lower number means more privileged
  assign back_higher_o = (rb < rf);
  assign back_lower_o  = (rb > rf);
endmodule

// File: rtl/insn_addr_queue.sv
module insn_addr_queue
  import iaq_pkg::*;
#(
  parameter int  SPACE_W      = 32,
  parameter bit  REDUCED_PRIV = 1'b0,
  localparam int SPC_PW       = (SPACE_W == 0) ? 1 : SPACE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  input  logic              br_taken_i,
  input  logic [ENT_W-1:0]  br_tgt_ofs_i,
  input  logic [SPC_PW-1:0] br_tgt_spc_i,
  input  logic              restore_i,
  input  logic [ENT_W-1:0]  rs_front_ofs_i,
  input  logic [SPC_PW-1:0] rs_front_spc_i,
  input  logic [ENT_W-1:0]  rs_back_ofs_i,
  input  logic [SPC_PW-1:0] rs_back_spc_i,
  input  logic              hi_trap_en_i,
  input  logic              lo_trap_en_i,
  input  logic              br_trap_en_i,
  output logic [ENT_W-1:0]  front_ofs_o,
  output logic [SPC_PW-1:0] front_spc_o,
  output logic [ENT_W-1:0]  back_ofs_o,
  output logic [SPC_PW-1:0] back_spc_o,
  output logic              hi_trap_o,
  output logic              lo_trap_o,
  output logic              br_trap_o
);
  localparam logic [ENT_W-1:0] FRONT_RST = '0;
  localparam logic [ENT_W-1:0] BACK_RST  = ENT_W'(1) << PL_W;

  // named internal events
  bk_src_e           bk_src;
  logic              front_ld, taken_ld, taken_d, taken_q;
  logic              back_ld;
  logic [ENT_W-1:0]  front_d, back_d;
  logic [SPC_PW-1:0] front_sd, back_sd;
  logic              back_higher, back_lower;

  iaq_ctl u_ctl (
    .adv_i      (adv_i),
    .br_taken_i (br_taken_i),
    .restore_i  (restore_i),
    .bk_src_o   (bk_src),
    .front_ld_o (front_ld),
    .taken_ld_o (taken_ld),
    .taken_d_o  (taken_d)
  );

  always_comb begin
    front_d  = restore_i ? rs_front_ofs_i : back_ofs_o;
    front_sd = restore_i ? rs_front_spc_i : back_spc_o;
    back_ld  = (bk_src != BK_HOLD);
    unique case (bk_src)
      BK_RESTORE: begin back_d = rs_back_ofs_i;        back_sd = rs_back_spc_i; end
      BK_BRANCH:  begin back_d = br_tgt_ofs_i;         back_sd = br_tgt_spc_i;  end
      BK_SEQ:     begin back_d = seq_succ(back_ofs_o); back_sd = back_spc_o;    end
      default:    begin back_d = back_ofs_o;           back_sd = back_spc_o;    end
    endcase
  end

  iaq_entry #(.SPACE_W(SPACE_W), .RST_OFS(FRONT_RST)) u_front (
    .clk   (clk),
    .rst_n (rst_n),
    .ld_i  (front_ld),
    .ofs_d (front_d),
    .spc_d (front_sd),
    .ofs_q (front_ofs_o),
    .spc_q (front_spc_o)
  );

  iaq_entry #(.SPACE_W(SPACE_W), .RST_OFS(BACK_RST)) u_back (
    .clk   (clk),
    .rst_n (rst_n),
    .ld_i  (back_ld),
    .ofs_d (back_d),
    .spc_d (back_sd),
    .ofs_q (back_ofs_o),
    .spc_q (back_spc_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        taken_q <= 1'b0;
    else if (taken_ld) taken_q <= taken_d;
  end

  iaq_priv_cmp #(.REDUCED_PRIV(REDUCED_PRIV)) u_cmp (
    .front_pl_i    (front_ofs_o[PL_W-1:0]),
    .back_pl_i     (back_ofs_o[PL_W-1:0]),
    .back_higher_o (back_higher),
    .back_lower_o  (back_lower)
  );

  assign hi_trap_o = hi_trap_en_i & back_higher;
  assign lo_trap_o = lo_trap_en_i & back_lower;
  assign br_trap_o = br_trap_en_i & taken_q;
endmodule

// File: rtl/iaq_chk.sv
module iaq_chk
  import iaq_pkg::*;
#(
  parameter int  SPACE_W = 32,
  localparam int SPC_PW  = (SPACE_W == 0) ? 1 : SPACE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              adv_i,
  input logic              br_taken_i,
  input logic              restore_i,
  input logic [ENT_W-1:0]  br_tgt_ofs_i,
  input logic [ENT_W-1:0]  rs_front_ofs_i,
  input logic [ENT_W-1:0]  rs_back_ofs_i,
  input logic [ENT_W-1:0]  front_ofs_o,
  input logic [SPC_PW-1:0] front_spc_o,
  input logic [ENT_W-1:0]  back_ofs_o,
  input logic [SPC_PW-1:0] back_spc_o,
  input logic              hi_trap_o,
  input logic              lo_trap_o,
  input logic              br_trap_o,
  input logic              br_trap_en_i
);
  assert_front_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !restore_i) |=> (front_ofs_o == $past(back_ofs_o)) && (front_spc_o == $past(back_spc_o)));

  assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !br_taken_i && !restore_i) |=>
      (back_ofs_o[1:0] == $past(back_ofs_o[1:0])) && $stable(back_spc_o) &&
      (back_ofs_o[ENT_W-1:PL_W] == $past(back_ofs_o[ENT_W-1:PL_W]) + OFS_W'(1)));

  assert_branch_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && br_taken_i && !restore_i) |=> (back_ofs_o == $past(br_tgt_ofs_i)));

  assert_restore_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restore_i |=> (front_ofs_o == $past(rs_front_ofs_i)) && (back_ofs_o == $past(rs_back_ofs_i)));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !restore_i) |=> $stable(front_ofs_o) && $stable(back_ofs_o) &&
                               $stable(front_spc_o) && $stable(back_spc_o));

  assert_priv_traps_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_trap_o && lo_trap_o));

  assert_br_trap_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    br_trap_o |-> br_trap_en_i);

  assert_br_trap_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_i || (adv_i && !br_taken_i)) |=> !br_trap_o);
endmodule

bind insn_addr_queue iaq_chk #(.SPACE_W(SPACE_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .adv_i          (adv_i),
  .br_taken_i     (br_taken_i),
  .restore_i      (restore_i),
  .br_tgt_ofs_i   (br_tgt_ofs_i),
  .rs_front_ofs_i (rs_front_ofs_i),
  .rs_back_ofs_i  (rs_back_ofs_i),
  .front_ofs_o    (front_ofs_o),
  .front_spc_o    (front_spc_o),
  .back_ofs_o     (back_ofs_o),
  .back_spc_o     (back_spc_o),
  .hi_trap_o      (hi_trap_o),
  .lo_trap_o      (lo_trap_o),
  .br_trap_o      (br_trap_o),
  .br_trap_en_i   (br_trap_en_i)
);

// File: tb/insn_addr_queue_tb_top.sv
`timescale 1ns/1ps
module insn_addr_queue_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        adv, br, ld, he, le, be;
  logic [31:0] tgt, tgts, rf, rb, rfs, rbs;

  logic [31:0] f_fo, f_fs, f_bo, f_bs;
  logic        f_hi, f_lo, f_bt;
  logic [31:0] r_fo, r_bo;
  logic        r_fs, r_bs, r_hi, r_lo, r_bt;

  insn_addr_queue dut_i (
    .clk(clk), .rst_n(rst_n), .adv_i(adv), .br_taken_i(br),
    .br_tgt_ofs_i(tgt), .br_tgt_spc_i(tgts), .restore_i(ld),
    .rs_front_ofs_i(rf), .rs_front_spc_i(rfs), .rs_back_ofs_i(rb), .rs_back_spc_i(rbs),
    .hi_trap_en_i(he), .lo_trap_en_i(le), .br_trap_en_i(be),
    .front_ofs_o(f_fo), .front_spc_o(f_fs), .back_ofs_o(f_bo), .back_spc_o(f_bs),
    .hi_trap_o(f_hi), .lo_trap_o(f_lo), .br_trap_o(f_bt));

  insn_addr_queue #(.SPACE_W(0), .REDUCED_PRIV(1'b1)) dut_r (
    .clk(clk), .rst_n(rst_n), .adv_i(adv), .br_taken_i(br),
    .br_tgt_ofs_i(tgt), .br_tgt_spc_i(tgts[0]), .restore_i(ld),
    .rs_front_ofs_i(rf), .rs_front_spc_i(rfs[0]), .rs_back_ofs_i(rb), .rs_back_spc_i(rbs[0]),
    .hi_trap_en_i(he), .lo_trap_en_i(le), .br_trap_en_i(be),
    .front_ofs_o(r_fo), .front_spc_o(r_fs), .back_ofs_o(r_bo), .back_spc_o(r_bs),
    .hi_trap_o(r_hi), .lo_trap_o(r_lo), .br_trap_o(r_bt));

  int checks = 0;
  int failures = 0;

  // reference state
  logic [31:0] m_f, m_b, m_fs, m_bs;
  bit          m_tk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare(input string rf_tag, input string rb_tag);
    int pf, pb, cf, cb;
    bit ehi, elo, rhi, rlo, ebt;
    pf = int'(m_f[1:0]); pb = int'(m_b[1:0]);
    cf = (pf != 0) ? 1 : 0; cb = (pb != 0) ? 1 : 0;
    ehi = he && (pb < pf); elo = le && (pb > pf);
    rhi = he && (cb < cf); rlo = le && (cb > cf);
    ebt = be && m_tk;
    chk(f_fo == m_f,  rf_tag, "front_ofs", f_fo, m_f);
    chk(f_fs == m_fs, rf_tag, "front_spc", f_fs, m_fs);
    chk(f_bo == m_b,  rb_tag, "back_ofs",  f_bo, m_b);
    chk(f_bs == m_bs, rb_tag, "back_spc",  f_bs, m_bs);
    chk(r_fo == m_f,  rf_tag, "red front_ofs", r_fo, m_f);
    chk(r_bo == m_b,  rb_tag, "red back_ofs",  r_bo, m_b);
    chk(f_hi == ehi, "R7", "hi_trap", 32'(f_hi), 32'(ehi));
    chk(f_lo == elo, "R8", "lo_trap", 32'(f_lo), 32'(elo));
    chk(r_hi == rhi, "R9", "red hi_trap", 32'(r_hi), 32'(rhi));
    chk(r_lo == rlo, "R9", "red lo_trap", 32'(r_lo), 32'(rlo));
    chk(f_bt == ebt, "R10", "br_trap", 32'(f_bt), 32'(ebt));
    chk(r_bt == ebt, "R10", "red br_trap", 32'(r_bt), 32'(ebt));
    chk(r_fs == 1'b0 && r_bs == 1'b0, "R11", "absent space", {30'd0, r_fs, r_bs}, 32'd0);
  endtask

  task automatic step(input bit a, input bit b, input bit l, input logic [31:0] t, input logic [31:0] ts,
                      input logic [31:0] xf, input logic [31:0] xb, input logic [31:0] xfs, input logic [31:0] xbs,
                      input bit h, input bit lw, input bit bt);
    string ft, bkt;
    adv = a; br = b; ld = l; tgt = t; tgts = ts; rf = xf; rb = xb; rfs = xfs; rbs = xbs;
    he = h; le = lw; be = bt;
    @(posedge clk);
    if (l) begin
      m_f = xf; m_fs = xfs; m_b = xb; m_bs = xbs; m_tk = 0;
      ft = "R5"; bkt = "R5";
    end else if (a) begin
      m_f = m_b; m_fs = m_bs;
      if (b) begin m_b = t; m_bs = ts; m_tk = 1; bkt = "R4"; end
      else begin m_b = {m_b[31:2] + 30'd1, m_b[1:0]}; m_tk = 0; bkt = "R3"; end
      ft = "R2";
    end else begin
      ft = "R6"; bkt = "R6";
    end
    @(negedge clk);
    compare(ft, bkt);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 0; adv = 0; br = 0; ld = 0; tgt = 0; tgts = 0; rf = 0; rb = 0; rfs = 0; rbs = 0;
    he = 1; le = 1; be = 1;
    m_f = 32'h0; m_b = 32'h4; m_fs = 0; m_bs = 0; m_tk = 0;
    repeat (3) @(negedge clk);
    chk(f_fo == 32'h0 && f_bo == 32'h4, "R1", "reset offsets", f_bo, 32'h4);
    chk(f_fs == 0 && f_bs == 0, "R1", "reset spaces", f_fs | f_bs, 32'h0);
    chk(!f_hi && !f_lo && !f_bt, "R1", "reset traps", {29'd0, f_hi, f_lo, f_bt}, 32'h0);
    rst_n = 1;
    @(negedge clk);
    compare("R1", "R1");
    // sequential flow
    step(1,0,0, 0,0, 0,0,0,0, 1,1,1);
    step(1,0,0, 0,0, 0,0,0,0, 1,1,1);
    // idle with branch noise ignored (R6)
    step(0,1,0, 32'hDEAD_BEE3, 32'h55, 0,0,0,0, 1,1,1);
    // branch to a less-privileged target, then more-privileged return
    step(1,1,0, 32'h0000_1003, 32'h77, 0,0,0,0, 1,1,1);
    step(1,0,0, 0,0, 0,0,0,0, 1,1,1);
    step(1,1,0, 32'h0000_2000, 32'h12, 0,0,0,0, 1,1,1);
    step(0,0,0, 0,0, 0,0,0,0, 1,1,0);
    step(1,0,0, 0,0, 0,0,0,0, 1,1,1);
    // restore with wrap at the top of the offset range
    step(0,0,1, 0,0, 32'h0000_0102, 32'hFFFF_FFFD, 32'hA, 32'hB, 1,1,1);
    step(1,0,0, 0,0, 0,0,0,0, 1,1,1);
    // restore wins over simultaneous branch advance (R5)
    step(1,1,1, 32'h0000_4442, 32'h9, 32'h0000_0501, 32'h0000_0603, 32'hC, 32'hD, 1,1,1);
    // reduced-class equivalence: 1 to 3 (R9)
    step(0,0,1, 0,0, 32'h0000_0011, 32'h0000_0023, 32'h1, 32'h2, 1,1,1);
    step(0,0,1, 0,0, 32'h0000_0010, 32'h0000_0022, 32'h1, 32'h2, 0,1,1);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r1, r2, r3, r4;
      r1 = $urandom; r2 = $urandom; r3 = $urandom; r4 = $urandom;
      step(r1[0] | r1[1], r1[2], (r1[5:3] == 3'd0), r2, r3, r3 ^ r4, r4, r2 ^ r1, r1,
           r1[8], r1[9], r1[10]);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule